// File: doc/BRIEF.md
# Flash Security Gate with Backdoor Key Compare

This block keeps the two-bit security field of an on-chip flash and decides what a CPU write into an eight-byte key window means. A control register holds a key-access enable. When the enable is clear, a write into the window starts a flash program or erase command, and the block emits a one-cycle start pulse that carries the byte offset. When the enable is set, the same writes are taken as comparison-key bytes. After eight bytes arrive in order, they are compared with the eight stored key bytes, and a full match opens the part.

The security field is loaded from nonvolatile bits during reset. Of its four codes only `10` means unsecured. The field can leave the secure state by only two routes: a key match or a blank-check pass pulse from the flash controller. The block also holds a protection byte, which is copied from its nonvolatile shadow during reset and which the bus can read but never change. The bus has a single write strobe, and read data is registered.

Top module: `flash_sec_gate`

## Requirements
- R1: While `rst` is high, the security field is loaded from `nv_sec`. `secure` is 1 for the codes 00, 01 and 11, and 0 only for 10.
- R2: A `blank_ok` pulse sampled at a clock edge sets the field to 10, and `secure` is 0 after that same edge.
- R3: With key-access enable set, eight writes at window offsets 0,1,...,7 (addresses `KEY_BASE`+0 to +7) whose data equal `stored_key[8*i+:8]` raise `key_ok` for one cycle after the last write's edge. `secure` is 0 one cycle later, and the status register then reads 0x02.
- R4: Once unsecured, the field stays at 10 until the next reset.
- R5: A mismatching byte set, or a key write at an offset other than the next expected one, gives no `key_ok` and leaves the part secure. It also locks out key entry, so a later correct sequence is ignored until reset.
- R6: With key-access enable clear, a window write makes `cmd_start` high for exactly the one cycle after its edge, with `cmd_offset` equal to the address offset (low 3 bits). Such a write captures no key byte.
- R7: With key-access enable set, window writes never raise `cmd_start`.
- R8: The configuration register at `CFG_ADDR` resets to 0x00. Only bit 5 (key-access enable) is writable, and all other bits read 0.
- R9: The protection register at `PROT_ADDR` is loaded from `nv_prot` during reset and is readable at any time. Bus writes to it leave `prot_q` and its read value unchanged.
- R10: `bus_rdata` shows the register at `bus_addr` one cycle after the address is sampled. The status register at `STAT_ADDR` holds the security field in bits 1:0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads nonvolatile values |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Registered read data |
| nv_prot | input | 8 | Nonvolatile protection byte, sampled in reset |
| nv_sec | input | 2 | Nonvolatile security code, sampled in reset |
| blank_ok | input | 1 | Blank-check pass pulse |
| stored_key | input | 64 | Stored key, byte i at bits 8*i+7:8*i |
| secure | output | 1 | 1 while the part is secure |
| key_ok | output | 1 | One-cycle pulse on key match |
| cmd_start | output | 1 | One-cycle flash command start pulse |
| cmd_offset | output | 3 | Window offset of the starting write |
| prot_q | output | 8 | Protection register value |

## Verification
Every result has a fixed latency. `cmd_start`, `key_ok`, `bus_rdata` and a `blank_ok` unlock are visible one cycle after the edge that samples the stimulus. A key unlock shows on `secure` one cycle after `key_ok`. The bench drives inputs and samples outputs on falling edges, so each check reads the value due after exactly the counted number of rising edges, and a check one edge later confirms that the pulses have dropped. Lockout and the ignored protection writes are observed by later reads, and by retrying a correct key through the normal bus.

// File: rtl/flash_sec_pkg.sv
`timescale 1ns/1ps
package flash_sec_pkg;
  typedef logic [1:0] sec_t;
  localparam sec_t SEC_OPEN = 2'b10;
  localparam int KACC_BIT = 5;

  function automatic logic is_secure(input sec_t s);
    return (s != SEC_OPEN);
  endfunction
endpackage

// File: rtl/flash_sec_regs.sv
`timescale 1ns/1ps
module flash_sec_regs
  import flash_sec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 3,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFFB0,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h1820,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'h1821,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1822
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [DATA_W-1:0] nv_prot,
  input  sec_t              sec,
  output logic              kacc,
  output logic [DATA_W-1:0] prot_q,
  output logic [DATA_W-1:0] rdata,
  output logic              key_wr,
  output logic [IDX_W-1:0]  key_idx,
  output logic              cmd_start,
  output logic [IDX_W-1:0]  cmd_offset
);
  logic in_win, win_wr;
  logic [DATA_W-1:0] rd_mux;

  assign in_win  = (addr[ADDR_W-1:IDX_W] == KEY_BASE[ADDR_W-1:IDX_W]);
  assign win_wr  = we && in_win;
  assign key_wr  = win_wr && kacc;
  assign key_idx = addr[IDX_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (addr == CFG_ADDR)       rd_mux[KACC_BIT] = kacc;
    else if (addr == PROT_ADDR) rd_mux = prot_q;
    else if (addr == STAT_ADDR) rd_mux[1:0] = sec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kacc       <= 1'b0;
      prot_q     <= nv_prot;
      rdata      <= '0;
      cmd_start  <= 1'b0;
      cmd_offset <= '0;
    end else begin
      rdata     <= rd_mux;
      cmd_start <= win_wr && !kacc;
      if (win_wr && !kacc) cmd_offset <= addr[IDX_W-1:0];
      if (we && addr == CFG_ADDR) kacc <= wdata[KACC_BIT];
    end
  end
endmodule

// File: rtl/flash_sec_keycmp.sv
`timescale 1ns/1ps
module flash_sec_keycmp #(
  parameter int DATA_W = 8,
  parameter int KEY_BYTES = 8,
  parameter int IDX_W = $clog2(KEY_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        key_wr,
  input  logic [IDX_W-1:0]            key_idx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [KEY_BYTES*DATA_W-1:0] stored_key,
  output logic                        key_ok
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_BYTES - 1);

  logic [DATA_W-1:0] kbuf [KEY_BYTES];
  logic [KEY_BYTES*DATA_W-1:0] cand;
  logic [IDX_W-1:0] ptr;
  logic locked, in_order, at_last;

  assign in_order = (key_idx == ptr);
  assign at_last  = (ptr == LAST);

  for (genvar i = 0; i < KEY_BYTES; i++) begin : g_cand
    if (i == KEY_BYTES - 1) begin : g_last
      assign cand[i*DATA_W +: DATA_W] = wdata;
    end else begin : g_held
      assign cand[i*DATA_W +: DATA_W] = kbuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      locked <= 1'b0;
      key_ok <= 1'b0;
    end else begin
      key_ok <= 1'b0;
      if (key_wr && !locked) begin
        if (!in_order) begin
          locked <= 1'b1;
        end else if (at_last) begin
          locked <= 1'b1;
          key_ok <= (cand == stored_key);
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (key_wr && !locked && in_order && !at_last) kbuf[ptr] <= wdata;
  end
endmodule

// File: rtl/flash_sec_state.sv
`timescale 1ns/1ps
module flash_sec_state
  import flash_sec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sec_t nv_sec,
  input  logic key_ok,
  input  logic blank_ok,
  output sec_t sec,
  output logic secure
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sec    <= nv_sec;
      secure <= is_secure(nv_sec);
    end else if (key_ok || blank_ok) begin
      sec    <= SEC_OPEN;
      secure <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_sec_gate.sv
`timescale 1ns/1ps
module flash_sec_gate
  import flash_sec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int KEY_BYTES = 8,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFFB0,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h1820,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 16'h1821,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1822,
  localparam int IDX_W = $clog2(KEY_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [DATA_W-1:0]           nv_prot,
  input  logic [1:0]                  nv_sec,
  input  logic                        blank_ok,
  input  logic [KEY_BYTES*DATA_W-1:0] stored_key,
  output logic                        secure,
  output logic                        key_ok,
  output logic                        cmd_start,
  output logic [IDX_W-1:0]            cmd_offset,
  output logic [DATA_W-1:0]           prot_q
);
  sec_t sec;
  logic kacc, key_wr;
  logic [IDX_W-1:0] key_idx;

  flash_sec_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .KEY_BASE(KEY_BASE),
    .CFG_ADDR(CFG_ADDR), .PROT_ADDR(PROT_ADDR), .STAT_ADDR(STAT_ADDR)
  ) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .nv_prot(nv_prot), .sec(sec), .kacc(kacc), .prot_q(prot_q),
    .rdata(bus_rdata), .key_wr(key_wr), .key_idx(key_idx),
    .cmd_start(cmd_start), .cmd_offset(cmd_offset)
  );

  flash_sec_keycmp #(
    .DATA_W(DATA_W), .KEY_BYTES(KEY_BYTES), .IDX_W(IDX_W)
  ) key_i (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_idx(key_idx),
    .wdata(bus_wdata), .stored_key(stored_key), .key_ok(key_ok)
  );

  flash_sec_state state_i (
    .clk(clk), .rst(rst), .nv_sec(nv_sec), .key_ok(key_ok),
    .blank_ok(blank_ok), .sec(sec), .secure(secure)
  );
endmodule

// File: rtl/flash_sec_gate_chk.sv
`timescale 1ns/1ps
module flash_sec_gate_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 3,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFFB0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              blank_ok,
  input logic              kacc,
  input logic              secure,
  input logic              key_ok,
  input logic              cmd_start,
  input logic [DATA_W-1:0] prot_q
);
  logic win_wr;
  assign win_wr = bus_we && (bus_addr[ADDR_W-1:IDX_W] == KEY_BASE[ADDR_W-1:IDX_W]);

  // R2 R3: leaving the secure state needs a key match or a blank-check pass
  p_unlock_path_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $fell(secure)) |-> $past(key_ok || blank_ok));

  // R4: unsecured is sticky
  p_sticky_open_r4: assert property (@(posedge clk) disable iff (rst)
    !secure |=> !secure);

  // R6: a command pulse follows a window write
  p_cmd_src_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cmd_start) |-> $past(win_wr));

  // R7: key-access enable blocks command pulses
  p_kacc_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cmd_start) |-> !$past(kacc));

  // R7: no cycle has both a command start and a key match
  p_excl_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_start, key_ok}));

  // R9: protection value never moves outside reset
  p_prot_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(prot_q));
endmodule

bind flash_sec_gate flash_sec_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .KEY_BASE(KEY_BASE)
) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .blank_ok(blank_ok), .kacc(kacc), .secure(secure), .key_ok(key_ok),
  .cmd_start(cmd_start), .prot_q(prot_q)
);

// File: tb/flash_sec_gate_tb_top.sv
`timescale 1ns/1ps
module flash_sec_gate_tb_top;
  localparam logic [15:0] KB   = 16'hFFB0;
  localparam logic [15:0] CFGA = 16'h1820;
  localparam logic [15:0] PRTA = 16'h1821;
  localparam logic [15:0] STTA = 16'h1822;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] nv_prot = 8'h00;
  logic [1:0] nv_sec = 2'b00;
  logic blank_ok = 1'b0;
  logic [63:0] stored_key = '0;
  logic secure, key_ok, cmd_start;
  logic [2:0] cmd_offset;
  logic [7:0] prot_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_sec_gate dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .nv_prot(nv_prot), .nv_sec(nv_sec),
    .blank_ok(blank_ok), .stored_key(stored_key), .secure(secure),
    .key_ok(key_ok), .cmd_start(cmd_start), .cmd_offset(cmd_offset), .prot_q(prot_q)
  );

  function automatic logic exp_secure(input logic [1:0] s);
    return s != 2'b10;
  endfunction

  function automatic logic [7:0] exp_cfg(input logic [7:0] w);
    return w & 8'h20;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic [7:0] p);
    @(negedge clk);
    rst = 1'b1; nv_sec = s; nv_prot = p; bus_we = 1'b0; blank_ok = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic key_seq(input logic [63:0] k, input int bad_idx);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = k[8*i +: 8];
      if (i == bad_idx) b = b ^ 8'h01;
      wr(KB + 16'(i), b);
      if (i < 7) chk("R7 no cmd_start in key mode", cmd_start, 1'b0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] p;
    void'($urandom(32'd4242));
    stored_key = {$urandom, $urandom};

    // R1 R8 R9 R10: every reset code
    for (int s = 0; s < 4; s++) begin
      p = 8'($urandom);
      do_reset(2'(s), p);
      chk("R1 secure after reset", secure, exp_secure(2'(s)));
      rd(STTA, r); chk("R10 status read", r, {6'b0, 2'(s)});
      rd(CFGA, r); chk("R8 cfg reset 0x00", r, 8'h00);
      rd(PRTA, r); chk("R9 prot loaded", r, p);
      chk("R9 prot_q", prot_q, p);
    end

    // R8: only bit 5 sticks
    do_reset(2'b00, 8'h5A);
    for (int n = 0; n < 6; n++) begin
      logic [7:0] w;
      w = (n == 0) ? 8'hFF : (n == 1) ? 8'hDF : 8'($urandom);
      wr(CFGA, w);
      rd(CFGA, r); chk("R8 cfg writable bit", r, exp_cfg(w));
    end

    // R9: writes to protection ignored
    for (int n = 0; n < 4; n++) begin
      wr(PRTA, 8'($urandom));
      chk("R9 prot_q unchanged", prot_q, 8'h5A);
      rd(PRTA, r); chk("R9 prot read unchanged", r, 8'h5A);
    end

    // R6: command pulses with key access off, random offsets
    wr(CFGA, 8'h00);
    for (int n = 0; n < 10; n++) begin
      logic [2:0] o;
      o = (n == 0) ? 3'd0 : (n == 1) ? 3'd7 : 3'($urandom);
      wr(KB + 16'(o), 8'($urandom));
      chk("R6 cmd_start pulse", cmd_start, 1'b1);
      chk("R6 cmd_offset", cmd_offset, o);
      @(negedge clk);
      chk("R6 cmd_start single cycle", cmd_start, 1'b0);
    end
    // R6: those writes captured nothing; correct key now works from offset 0
    wr(CFGA, 8'h20);
    key_seq(stored_key, -1);
    chk("R3 key_ok pulse", key_ok, 1'b1);
    chk("R7 no cmd on last key byte", cmd_start, 1'b0);
    chk("R3 still secure on key_ok cycle", secure, 1'b1);
    @(negedge clk);
    chk("R3 unsecured after match", secure, 1'b0);
    chk("R3 key_ok single cycle", key_ok, 1'b0);
    rd(STTA, r); chk("R3 status open", r, 8'h02);
    // R4: stays open
    for (int n = 0; n < 5; n++) @(negedge clk);
    chk("R4 remains unsecured", secure, 1'b0);

    // R5: wrong byte then correct retry
    do_reset(2'b11, 8'h00);
    wr(CFGA, 8'h20);
    key_seq(stored_key, int'($urandom_range(0, 7)));
    chk("R5 no key_ok on mismatch", key_ok, 1'b0);
    @(negedge clk);
    chk("R5 still secure", secure, 1'b1);
    key_seq(stored_key, -1);
    chk("R5 lockout blocks retry", key_ok, 1'b0);
    @(negedge clk);
    chk("R5 locked stays secure", secure, 1'b1);

    // R5: out-of-order write locks
    do_reset(2'b01, 8'h00);
    wr(CFGA, 8'h20);
    wr(KB + 16'd1, stored_key[15:8]);
    key_seq(stored_key, -1);
    chk("R5 out of order no key_ok", key_ok, 1'b0);
    @(negedge clk);
    chk("R5 out of order secure", secure, 1'b1);

    // R2: blank check pass
    do_reset(2'b00, 8'h00);
    blank_ok = 1'b1;
    @(posedge clk);
    @(negedge clk);
    blank_ok = 1'b0;
    chk("R2 blank check unlock", secure, 1'b0);
    rd(STTA, r); chk("R2 status open", r, 8'h02);
    chk("R4 open after blank", secure, 1'b0);

    // R1: reset re-secures
    do_reset(2'b00, 8'h00);
    chk("R1 reset re-secures", secure, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule